// File: doc/BRIEF.md
# Receive Lane Pattern Checker with Scaled Error Counter

This block checks the bit stream of one receive lane against a known test pattern. Each clock it may take one received bit, marked by a valid strobe. It predicts the next bit of the selected pattern and counts every bit that differs. Two patterns are pseudo-random sequences, of length 2^15-1 and 2^7-1. The other two are repeat checks: each bit must equal the bit ten valid positions earlier, or, in the inverted variant, its complement.

Software drives the block through a 32-bit control word. To prepare a check it sets the sync bit while the pattern is arriving, then clears it. While sync is high the checker loads its prediction state from the live stream, so no seed has to be written. After sync is released, mismatches are counted in a 15-bit counter. When that counter fills, an overflow flag switches it to a coarse count in units of 128 errors. The count and the flag are read through a one-stage snapshot pipeline: each read returns the value captured at the read before it.

Top module: `lane_pattern_checker`

## Requirements
- R1: After reset the mode, sync, count and overflow fields are all 0, and reg_rdata reads 0.
- R2: The control word has overflow at reg_wdata[31], count at [30:16], sync at [3] and mode at [2:0]. Bits [15:4] are ignored on write and read as 0. A write loads every field, including count and overflow.
- R3: A read strobe updates reg_rdata on the next cycle. Its count and overflow fields hold the values captured at the previous read (0 if there was none), and its sync and mode fields hold the current settings. reg_rdata does not change between reads.
- R4: No error is counted while sync is 1, or at any time since reset before sync has been set and then cleared.
- R5: Mode 1 predicts d[n] = d[n-14] xor d[n-15]. Once at least 15 bits have been seeded under sync, every valid bit that differs from the predicted sequence counts one error, and the predictor keeps running on its own predicted bits.
- R6: Mode 2 predicts d[n] = d[n-6] xor d[n-7]. The seeding and counting rules are the same as in R5, with at least 7 seed bits.
- R7: Mode 3 counts an error when a valid bit differs from the valid bit received 10 positions earlier. The first 10 valid bits after sync is released are not checked.
- R8: Mode 4 counts an error when a valid bit equals the valid bit received 10 positions earlier. The warm-up is the same as in R7.
- R9: Modes 0, 5, 6 and 7 never count an error.
- R10: rx_bit is ignored while rx_valid is 0, and at most one error is counted per cycle.
- R11: An error that arrives while overflow is 0 and count is 32767 sets overflow to 1 and count to 255. After that, count rises by one for every 128 errors.
- R12: While overflow is 1 and count is 32767, count stays fixed. A write clears the hidden divide-by-128 stage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_valid | input | 1 | Marks rx_bit as a received bit |
| rx_bit | input | 1 | Received data bit |
| reg_wr | input | 1 | Write strobe for the control word |
| reg_rd | input | 1 | Read strobe, which advances the snapshot pipeline |
| reg_wdata | input | 32 | Control word to write |
| reg_rdata | output | 32 | Read data, valid from the cycle after reg_rd |

## Verification
An error is counted at the clock edge that samples the offending valid bit, with no added latency. The count becomes visible on reg_rdata only through two read strobes: the first one captures the value, and the second one, one cycle later, presents it. The bench therefore always idles the lane before a pair of reads and compares the second result. It samples reg_rdata on the falling edge that follows each read strobe. The prediction state is armed one cycle after sync falls, so the bench leaves the lane idle for a few cycles after each release write before it sends data.

// File: rtl/pchk_pkg.sv
package pchk_pkg;
  localparam int CNT_W    = 15;
  localparam int MODE_W   = 3;
  localparam int OV_POS   = 31;
  localparam int CNT_LSB  = 16;
  localparam int SYNC_POS = 3;

  typedef enum logic [MODE_W-1:0] {
    MODE_OFF     = 3'd0,
    MODE_PRBS15  = 3'd1,
    MODE_PRBS7   = 3'd2,
    MODE_REPEAT  = 3'd3,
    MODE_INVREP  = 3'd4
  } chk_mode_e;

  function automatic logic mode_is_prbs(logic [MODE_W-1:0] m);
    return (m == MODE_PRBS15) || (m == MODE_PRBS7);
  endfunction

  function automatic logic mode_is_rep(logic [MODE_W-1:0] m);
    return (m == MODE_REPEAT) || (m == MODE_INVREP);
  endfunction
endpackage

// File: rtl/pchk_predict.sv
module pchk_predict
  import pchk_pkg::*;
#(
  parameter int REP_DIST = 10,
  parameter int LFSR_W   = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_valid,
  input  logic              rx_bit,
  input  logic [MODE_W-1:0] mode,
  input  logic              sync,
  output logic              err_pulse
);
  localparam int FILL_W = $clog2(REP_DIST + 1);
  localparam logic [FILL_W-1:0] FILL_FULL = FILL_W'(REP_DIST);

  logic [LFSR_W-1:0]   lfsr_q;
  logic [REP_DIST-1:0] hist_q;
  logic [FILL_W-1:0]   fill_q;
  logic                sync_d, armed_q;

  // next bit of the selected pseudo-random sequence, newest bit at index 0
  function automatic logic prbs_next(logic [LFSR_W-1:0] s, logic [MODE_W-1:0] m);
    if (m == MODE_PRBS15) return s[13] ^ s[14];
    return s[5] ^ s[6];
  endfunction

  logic is_prbs, is_rep, expect_bit, check_en, lfsr_in;
  assign is_prbs = mode_is_prbs(mode);
  assign is_rep  = mode_is_rep(mode);

  always_comb begin
    if (is_prbs)                  expect_bit = prbs_next(lfsr_q, mode);
    else if (mode == MODE_INVREP) expect_bit = ~hist_q[REP_DIST-1];
    else                          expect_bit = hist_q[REP_DIST-1];
  end

  assign check_en  = rx_valid && !sync && armed_q &&
                     (is_prbs || (is_rep && fill_q == FILL_FULL));
  assign err_pulse = check_en && (rx_bit != expect_bit);
  // once checking, the sequence runs on its own prediction
  assign lfsr_in   = (check_en && is_prbs) ? expect_bit : rx_bit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lfsr_q  <= '0;
      hist_q  <= '0;
      fill_q  <= '0;
      sync_d  <= 1'b0;
      armed_q <= 1'b0;
    end else begin
      sync_d <= sync;
      if (sync)        armed_q <= 1'b0;
      else if (sync_d) armed_q <= 1'b1;
      if (rx_valid) begin
        lfsr_q <= {lfsr_q[LFSR_W-2:0], lfsr_in};
        hist_q <= {hist_q[REP_DIST-2:0], rx_bit};
      end
      if (sync)                                fill_q <= '0;
      else if (rx_valid && fill_q != FILL_FULL) fill_q <= fill_q + FILL_W'(1);
    end
  end

  a_r4_quiet_in_sync: assert property (@(posedge clk) disable iff (!rst_n)
    sync |-> !err_pulse);
  a_r4_no_err_at_release: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sync) |-> !err_pulse);
  a_r10_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_valid |-> !err_pulse);
  a_r9_off_modes: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 3'd0 || mode > 3'd4) |-> !err_pulse);
endmodule

// File: rtl/pchk_errcnt.sv
module pchk_errcnt #(
  parameter int CNT_W     = 15,
  parameter int PRE_W     = 7,
  parameter int OV_RELOAD = 255
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc,
  input  logic             ld_en,
  input  logic             ld_ov,
  input  logic [CNT_W-1:0] ld_cnt,
  output logic             ov,
  output logic [CNT_W-1:0] cnt
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam logic [PRE_W-1:0] PRE_MAX = {PRE_W{1'b1}};
  localparam int ST_W = 1 + CNT_W + PRE_W;

  logic [PRE_W-1:0] pre_q;

  // one error applied to {overflow, count, prescaler}
  function automatic logic [ST_W-1:0] count_step(logic o, logic [CNT_W-1:0] c,
                                                 logic [PRE_W-1:0] p);
    if (!o) begin
      if (c == CNT_MAX) return {1'b1, CNT_W'(OV_RELOAD), PRE_W'(0)};
      return {1'b0, c + CNT_W'(1), p};
    end
    if (c == CNT_MAX) return {o, c, p};
    if (p == PRE_MAX) return {1'b1, c + CNT_W'(1), PRE_W'(0)};
    return {1'b1, c, p + PRE_W'(1)};
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ov    <= 1'b0;
      cnt   <= '0;
      pre_q <= '0;
    end else if (ld_en) begin
      ov    <= ld_ov;
      cnt   <= ld_cnt;
      pre_q <= '0;
    end else if (inc) begin
      {ov, cnt, pre_q} <= count_step(ov, cnt, pre_q);
    end
  end

  a_r11_plain_inc: assert property (@(posedge clk) disable iff (!rst_n)
    (!ov && cnt != CNT_MAX && inc && !ld_en) |=> (!ov && cnt == $past(cnt) + CNT_W'(1)));
  a_r11_ovf_entry: assert property (@(posedge clk) disable iff (!rst_n)
    (!ov && cnt == CNT_MAX && inc && !ld_en) |=> (ov && cnt == CNT_W'(OV_RELOAD)));
  a_r12_saturated: assert property (@(posedge clk) disable iff (!rst_n)
    (ov && cnt == CNT_MAX && !ld_en) |=> (ov && $stable(cnt)));
  a_r12_ov_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (ov && !ld_en) |=> ov);
endmodule

// File: rtl/pchk_regs.sv
module pchk_regs
  import pchk_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [31:0]       reg_wdata,
  input  logic              cur_ov,
  input  logic [CNT_W-1:0]  cur_cnt,
  output logic [MODE_W-1:0] mode,
  output logic              sync,
  output logic              ld_en,
  output logic              ld_ov,
  output logic [CNT_W-1:0]  ld_cnt,
  output logic [31:0]       reg_rdata
);
  localparam int RSVD_W = CNT_LSB - SYNC_POS - 1;

  logic             snap_ov;
  logic [CNT_W-1:0] snap_cnt;
  logic             unused_rsvd;

  assign ld_en       = reg_wr;
  assign ld_ov       = reg_wdata[OV_POS];
  assign ld_cnt      = reg_wdata[CNT_LSB +: CNT_W];
  assign unused_rsvd = ^reg_wdata[SYNC_POS+1 +: RSVD_W];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode      <= '0;
      sync      <= 1'b0;
      snap_ov   <= 1'b0;
      snap_cnt  <= '0;
      reg_rdata <= '0;
    end else begin
      if (reg_wr) begin
        mode <= reg_wdata[MODE_W-1:0];
        sync <= reg_wdata[SYNC_POS];
      end
      if (reg_rd) begin
        reg_rdata <= {snap_ov, snap_cnt, {RSVD_W{1'b0}}, sync, mode};
        snap_ov   <= cur_ov;
        snap_cnt  <= cur_cnt;
      end
    end
  end

  a_r3_hold_between_reads: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_rd |=> $stable(reg_rdata));
  a_r3_live_ctrl: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rd |=> reg_rdata[SYNC_POS:0] == $past({sync, mode}));
  a_r2_rsvd_zero: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rd |=> reg_rdata[SYNC_POS+1 +: RSVD_W] == '0);
endmodule

// File: rtl/lane_pattern_checker.sv
module lane_pattern_checker
  import pchk_pkg::*;
#(
  parameter int REP_DIST  = 10,
  parameter int PRE_W     = 7,
  parameter int OV_RELOAD = 255
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        rx_valid,
  input  logic        rx_bit,
  input  logic        reg_wr,
  input  logic        reg_rd,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata
);
  logic [MODE_W-1:0] mode;
  logic              sync, ld_en, ld_ov, err_pulse, cur_ov;
  logic [CNT_W-1:0]  ld_cnt, cur_cnt;

  pchk_regs u_regs (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_wdata(reg_wdata), .cur_ov(cur_ov), .cur_cnt(cur_cnt),
    .mode(mode), .sync(sync), .ld_en(ld_en), .ld_ov(ld_ov),
    .ld_cnt(ld_cnt), .reg_rdata(reg_rdata)
  );

  pchk_predict #(.REP_DIST(REP_DIST), .LFSR_W(15)) u_predict (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_bit(rx_bit),
    .mode(mode), .sync(sync), .err_pulse(err_pulse)
  );

  pchk_errcnt #(.CNT_W(CNT_W), .PRE_W(PRE_W), .OV_RELOAD(OV_RELOAD)) u_errcnt (
    .clk(clk), .rst_n(rst_n), .inc(err_pulse), .ld_en(ld_en),
    .ld_ov(ld_ov), .ld_cnt(ld_cnt), .ov(cur_ov), .cnt(cur_cnt)
  );
endmodule

// File: tb/lane_pattern_checker_bench.sv
module lane_pattern_checker_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rx_valid = 1'b0;
  logic        rx_bit = 1'b0;
  logic        reg_wr = 1'b0;
  logic        reg_rd = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;

  lane_pattern_checker u_lane_pattern_checker (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_bit(rx_bit),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
  );

  always #4 clk = ~clk;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;
  bit ideal [0:8191];
  bit recv  [0:8191];
  int pos = 0;
  int rel_cnt = 0;
  int exp_err = 0;

  task automatic check(string req, logic [31:0] act, logic [31:0] exp, string what);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%08h expected 0x%08h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  // expected {overflow, count} after n errors from a freshly written state
  function automatic logic [15:0] model_count(bit ov0, int cnt0, int n);
    bit o = ov0;
    int c = cnt0;
    int sub = 0;
    for (int i = 0; i < n; i++) begin
      if (!o && c == 32767) begin o = 1; c = 255; sub = 0; end
      else if (!o) c = c + 1;
      else if (c != 32767) begin
        sub = sub + 1;
        if (sub == 128) begin c = c + 1; sub = 0; end
      end
    end
    return {o, 15'(c)};
  endfunction

  task automatic wr_raw(logic [31:0] w);
    @(negedge clk); reg_wr = 1'b1; reg_wdata = w;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic wr_ctl(bit ov, int cnt, bit s, int m);
    wr_raw({ov, 15'(cnt), 12'h000, s, 3'(m)});
  endtask

  task automatic rd_once(output logic [31:0] v);
    @(negedge clk); reg_rd = 1'b1;
    @(negedge clk); reg_rd = 1'b0; v = reg_rdata;
  endtask

  task automatic rd_twice(output logic [31:0] v);
    logic [31:0] first;
    rd_once(first);
    rd_once(v);
  endtask

  task automatic idle(int n);
    repeat (n) begin
      @(negedge clk); rx_valid = 1'b0; rx_bit = 1'($urandom);
    end
  endtask

  task automatic send(bit b);
    while ($urandom_range(3) == 0) begin
      @(negedge clk); rx_valid = 1'b0; rx_bit = 1'($urandom);
    end
    @(negedge clk); rx_valid = 1'b1; rx_bit = b;
  endtask

  task automatic prepare(int m);
    for (int i = 0; i < 8192; i++) begin
      if (m == 1 && i >= 15)      ideal[i] = ideal[i-14] ^ ideal[i-15];
      else if (m == 2 && i >= 7)  ideal[i] = ideal[i-6] ^ ideal[i-7];
      else if (m == 3 && i >= 10) ideal[i] = ideal[i-10];
      else if (m == 4 && i >= 10) ideal[i] = !ideal[i-10];
      else                        ideal[i] = 1'($urandom);
    end
    ideal[0] = 1'b1;
    pos = 0;
  endtask

  task automatic stream(int m, int nbits, int rate);
    for (int k = 0; k < nbits; k++) begin
      bit b;
      b = ideal[pos];
      if (int'($urandom_range(255)) < rate) b = !b;
      send(b);
      recv[rel_cnt] = b;
      if ((m == 1 || m == 2) && b != ideal[pos]) exp_err++;
      if (m == 3 && rel_cnt >= 10 && b != recv[rel_cnt-10]) exp_err++;
      if (m == 4 && rel_cnt >= 10 && b == recv[rel_cnt-10]) exp_err++;
      pos++;
      rel_cnt++;
    end
    idle(2);
  endtask

  task automatic run_mode(int m, int nseed, int nbits, int rate);
    prepare(m);
    wr_ctl(0, 0, 1, m);
    for (int i = 0; i < nseed; i++) send(ideal[i]);
    pos = nseed;
    idle(2);
    wr_ctl(0, 0, 0, m);
    idle(3);
    rel_cnt = 0;
    exp_err = 0;
    stream(m, nbits, rate);
  endtask

  initial begin
    logic [31:0] v, v1;
    void'($urandom(32'd20240611));
    repeat (5) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;

    check("R1", reg_rdata, 32'h0, "read data after reset");
    rd_once(v);
    check("R1", v, 32'h0, "first read after reset");

    // never armed since reset
    wr_ctl(0, 0, 0, 2);
    prepare(0);
    for (int i = 0; i < 120; i++) send(1'($urandom));
    idle(2);
    rd_twice(v);
    check("R4", v[31:16], 32'h0, "count before any sync cycle");

    run_mode(2, 20, 400, 8);
    rd_twice(v);
    check("R6", v[31:16], 32'(model_count(0, 0, exp_err)), "lfsr7 error count");

    run_mode(1, 30, 600, 6);
    rd_twice(v);
    check("R5", v[31:16], 32'(model_count(0, 0, exp_err)), "lfsr15 error count");

    run_mode(3, 12, 500, 6);
    rd_twice(v);
    check("R7", v[31:16], 32'(model_count(0, 0, exp_err)), "repeat error count");

    run_mode(4, 12, 500, 6);
    rd_twice(v);
    check("R8", v[31:16], 32'(model_count(0, 0, exp_err)), "inverted repeat error count");

    for (int m = 0; m < 8; m++) begin
      if (m == 0 || m >= 5) begin
        run_mode(m, 12, 200, 40);
        rd_twice(v);
        check("R9", v[31:16], 32'h0, $sformatf("count in mode %0d", m));
      end
    end

    // sync held high with random data
    wr_ctl(0, 0, 1, 2);
    for (int i = 0; i < 200; i++) send(1'($urandom));
    idle(2);
    rd_twice(v);
    check("R4", v[31:16], 32'h0, "count while sync high");

    // idle cycles carrying random bits must not disturb the prediction
    run_mode(2, 20, 50, 0);
    idle(200);
    stream(2, 50, 0);
    rd_twice(v);
    check("R10", v[31:16], 32'h0, "count after idle cycles with random rx_bit");
    stream(2, 40, 256);
    rd_twice(v);
    check("R10", v[31:16], 32'(model_count(0, 0, 40)), "one error per flipped bit");

    // pipelined read: first read shows the snapshot of the last read
    wr_ctl(0, 1234, 0, 2);
    rd_once(v1);
    check("R3", v1[31:16], 32'(model_count(0, 0, 40)), "first read returns previous snapshot");
    rd_once(v);
    check("R3", v[31:16], 32'd1234, "second read returns written count");
    check("R3", v[3:0], 32'h2, "live sync and mode");

    wr_raw(32'hFFFF_FFFF);
    rd_twice(v);
    check("R2", v, 32'hFFFF_000F, "all-ones write readback");

    // overflow entry and scaled counting
    run_mode(2, 20, 30, 0);
    wr_ctl(0, 32767, 0, 2);
    stream(2, 1, 256);
    rd_twice(v);
    check("R11", v[31:16], 32'h80FF, "overflow entry");
    stream(2, 127, 256);
    rd_twice(v);
    check("R11", v[31:16], 32'h80FF, "127 scaled errors");
    stream(2, 1, 256);
    rd_twice(v);
    check("R11", v[31:16], 32'h8100, "128th scaled error");

    // saturation
    wr_ctl(1, 32766, 0, 2);
    stream(2, 300, 256);
    rd_twice(v);
    check("R12", v[31:16], 32'(model_count(1, 32766, 300)), "saturated count");
    stream(2, 200, 256);
    rd_twice(v);
    check("R12", v[31:16], 32'hFFFF, "count stays at saturation");

    // random mix of modes and error rates
    for (int t = 0; t < 4; t++) begin
      int m, rate;
      m = 1 + int'($urandom_range(3));
      rate = int'($urandom_range(30));
      run_mode(m, 20, 300, rate);
      rd_twice(v);
      check(m == 1 ? "R5" : m == 2 ? "R6" : m == 3 ? "R7" : "R8", v[31:16],
            32'(model_count(0, 0, exp_err)), $sformatf("random run mode %0d", m));
    end

    finished = 1;
    summary();
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end
endmodule